// File: doc/BRIEF.md
# Variable-Length Instruction Decoder

This block takes a ten-byte window fetched from instruction memory, together with the address that window starts at and an address-error flag from the memory, and splits it into the fields of one instruction of a byte-encoded 64-bit teaching instruction set. An instruction is one to ten bytes long. It always starts with an opcode byte and may carry a register byte and an eight-byte constant. The block returns the two opcode nibbles, both register selectors, the constant and the address of the following instruction. It also returns a processor status code that tells normal flow apart from a halt, a bad address and an undefined encoding.

Window byte k sits at bits [8k+7:8k], so byte 0 is the opcode byte. When the constant is present it is read little-endian: its lowest byte comes first in memory. A parameter chooses between a registered output stage (the default, one cycle of latency) and a purely combinational path.

Top module: `vlen_decoder`

## Requirements
- R1: `icode` is the upper nibble of window byte 0 and `ifun` is its lower nibble. Both are reported unchanged for every encoding.
- R2: Instruction codes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB carry a register byte at window byte 1, with `ra` taken from its upper nibble and `rb` from its lower nibble. Every other code, and every undefined encoding, reports 0xF (no register) on both.
- R3: Codes 0x3, 0x4 and 0x5 take `valc` from window bytes 2..9, and codes 0x7 and 0x8 take it from bytes 1..8. In both cases the lowest-addressed byte is the least significant. All other codes, and undefined encodings, report `valc` = 0.
- R4: `valp` = `pc` + length. The length is 1 for codes 0x0, 0x1 and 0x9, 2 for 0x2, 0x6, 0xA and 0xB, 9 for 0x7 and 0x8, and 10 for 0x3, 0x4 and 0x5. The sum wraps modulo 2^64.
- R5: An instruction code above 0xB is undefined. It gives `stat` = 4, `ra` = `rb` = 0xF, `valc` = 0 and `valp` = `pc` + 1.
- R6: A function code is valid only when it is 0..6 for codes 0x2 and 0x7, 0..3 for code 0x6, and 0 for every other defined code. An invalid function code is treated as an undefined encoding, as in R5.
- R7: When `mem_err` is high, `stat` = 3. This overrides both the halt status and the undefined-encoding status, and it leaves the decoded fields as R1 to R6 give them.
- R8: A halt (byte 0 = 0x00) without a memory error gives `stat` = 2. Any other valid encoding without a memory error gives `stat` = 1.
- R9: With the default registered output, every output reflects the inputs sampled at the previous rising clock edge. While `rst_n` is low, the outputs equal the decode of a no-op at address 0: `icode` = 1, `ifun` = 0, `ra` = `rb` = 0xF, `valc` = 0, `valp` = 1, `stat` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_win | input | 80 | Ten fetched bytes, byte 0 in bits [7:0] |
| pc | input | 64 | Address of window byte 0 |
| mem_err | input | 1 | Fetch hit an invalid address |
| icode | output | 4 | Instruction code |
| ifun | output | 4 | Function code |
| ra | output | 4 | First register selector, 0xF = none |
| rb | output | 4 | Second register selector, 0xF = none |
| valc | output | 64 | Decoded constant |
| valp | output | 64 | Address of the next sequential instruction |
| stat | output | 3 | Status: 1 normal, 2 halt, 3 bad address, 4 bad instruction |

## Verification
Within a single cycle, the memory-error status can coincide with either of the two other exceptional statuses: a halt opcode, or an undefined opcode or function code. The bench provokes both overlaps by raising `mem_err` while it presents a halt byte, and again while it presents an out-of-range opcode. It then checks that `stat` reads 3. It also checks that the undefined encoding still collapses its fields and its length to a single byte, and that a plain no-op under a memory error keeps its normal next address.

// File: rtl/vlen_dec_pkg.sv
package vlen_dec_pkg;

   localparam int NIB_W = 4;

   localparam logic [NIB_W-1:0] IC_HALT  = 4'h0;
   localparam logic [NIB_W-1:0] IC_NOP   = 4'h1;
   localparam logic [NIB_W-1:0] IC_MOVE  = 4'h2;
   localparam logic [NIB_W-1:0] IC_IMOV  = 4'h3;
   localparam logic [NIB_W-1:0] IC_STORE = 4'h4;
   localparam logic [NIB_W-1:0] IC_LOAD  = 4'h5;
   localparam logic [NIB_W-1:0] IC_ALU   = 4'h6;
   localparam logic [NIB_W-1:0] IC_JUMP  = 4'h7;
   localparam logic [NIB_W-1:0] IC_CALL  = 4'h8;
   localparam logic [NIB_W-1:0] IC_RET   = 4'h9;
   localparam logic [NIB_W-1:0] IC_PUSH  = 4'hA;
   localparam logic [NIB_W-1:0] IC_POP   = 4'hB;
   localparam logic [NIB_W-1:0] IC_LAST  = IC_POP;

   localparam logic [NIB_W-1:0] REG_NONE = 4'hF;

   localparam logic [NIB_W-1:0] MOVE_FUN_MAX = 4'd6;
   localparam logic [NIB_W-1:0] JUMP_FUN_MAX = 4'd6;
   localparam logic [NIB_W-1:0] ALU_FUN_MAX  = 4'd3;

   typedef enum logic [2:0] {
      ST_AOK = 3'd1,
      ST_HLT = 3'd2,
      ST_ADR = 3'd3,
      ST_INS = 3'd4
   } stat_e;

   function automatic logic carries_reg(input logic [NIB_W-1:0] ic);
      case (ic)
         IC_MOVE, IC_IMOV, IC_STORE, IC_LOAD,
         IC_ALU, IC_PUSH, IC_POP:            carries_reg = 1'b1;
         default:                            carries_reg = 1'b0;
      endcase
   endfunction

   function automatic logic carries_const(input logic [NIB_W-1:0] ic);
      case (ic)
         IC_IMOV, IC_STORE, IC_LOAD,
         IC_JUMP, IC_CALL:                   carries_const = 1'b1;
         default:                            carries_const = 1'b0;
      endcase
   endfunction

   function automatic logic fun_legal(input logic [NIB_W-1:0] ic,
                                      input logic [NIB_W-1:0] fn);
      case (ic)
         IC_MOVE: fun_legal = (fn <= MOVE_FUN_MAX);
         IC_JUMP: fun_legal = (fn <= JUMP_FUN_MAX);
         IC_ALU:  fun_legal = (fn <= ALU_FUN_MAX);
         default: fun_legal = (fn == '0);
      endcase
   endfunction

endpackage

// File: rtl/vlen_dec_class.sv
module vlen_dec_class
   import vlen_dec_pkg::*;
(
   input  logic [NIB_W-1:0] icode_i,
   input  logic [NIB_W-1:0] ifun_i,
   output logic             has_reg_o,
   output logic             has_const_o,
   output logic             illegal_o,
   output logic             is_halt_o
);

   logic code_ok;
   logic fun_ok;

   always_comb begin
      code_ok     = (icode_i <= IC_LAST);
      fun_ok      = fun_legal(icode_i, ifun_i);
      illegal_o   = !(code_ok && fun_ok);
      has_reg_o   = carries_reg(icode_i)   && !illegal_o;
      has_const_o = carries_const(icode_i) && !illegal_o;
      is_halt_o   = (icode_i == IC_HALT)   && !illegal_o;
   end

endmodule

// File: rtl/vlen_dec_fields.sv
module vlen_dec_fields
   import vlen_dec_pkg::*;
#(
   parameter int WORD_W    = 64,
   parameter int WIN_BYTES = 10
)(
   input  logic [WIN_BYTES*8-1:8] tail_i,
   input  logic                   has_reg_i,
   input  logic                   has_const_i,
   output logic [NIB_W-1:0]       ra_o,
   output logic [NIB_W-1:0]       rb_o,
   output logic [WORD_W-1:0]      valc_o
);

   localparam int WORD_BYTES = WORD_W / 8;

   logic [WORD_W-1:0] const_near;
   logic [WORD_W-1:0] const_far;

   for (genvar k = 0; k < WORD_BYTES; k++) begin : g_cbyte
      assign const_near[8*k +: 8] = tail_i[8*(k+1) +: 8];
      assign const_far[8*k +: 8]  = tail_i[8*(k+2) +: 8];
   end

   always_comb begin
      ra_o   = REG_NONE;
      rb_o   = REG_NONE;
      valc_o = '0;
      if (has_reg_i) begin
         ra_o = tail_i[15:12];
         rb_o = tail_i[11:8];
      end
      if (has_const_i) begin
         valc_o = has_reg_i ? const_far : const_near;
      end
   end

endmodule

// File: rtl/vlen_dec_next.sv
module vlen_dec_next #(
   parameter int ADDR_W = 64,
   parameter int WORD_W = 64
)(
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              has_reg_i,
   input  logic              has_const_i,
   output logic [ADDR_W-1:0] valp_o
);

   localparam int WORD_BYTES = WORD_W / 8;
   localparam int LEN_W      = $clog2(WORD_BYTES + 3);

   logic [LEN_W-1:0] len;

   always_comb begin
      len = LEN_W'(1);
      if (has_reg_i)   len = len + LEN_W'(1);
      if (has_const_i) len = len + LEN_W'(WORD_BYTES);
      valp_o = pc_i + ADDR_W'(len);
   end

endmodule

// File: rtl/vlen_dec_stage.sv
module vlen_dec_stage #(
   parameter int             BUS_W   = 8,
   parameter bit             REG_OUT = 1'b1,
   parameter logic [BUS_W-1:0] RST_VAL = '0
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BUS_W-1:0] d_i,
   output logic [BUS_W-1:0] q_o
);

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_o <= RST_VAL;
         else        q_o <= d_i;
      end
   end else begin : g_comb
      assign q_o = d_i;
   end

endmodule

// File: rtl/vlen_decoder.sv
module vlen_decoder
   import vlen_dec_pkg::*;
#(
   parameter int ADDR_W    = 64,
   parameter int WORD_W    = 64,
   parameter int WIN_BYTES = 10,
   parameter bit REG_OUT   = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [WIN_BYTES*8-1:0] fetch_win,
   input  logic [ADDR_W-1:0]      pc,
   input  logic                   mem_err,
   output logic [NIB_W-1:0]       icode,
   output logic [NIB_W-1:0]       ifun,
   output logic [NIB_W-1:0]       ra,
   output logic [NIB_W-1:0]       rb,
   output logic [WORD_W-1:0]      valc,
   output logic [ADDR_W-1:0]      valp,
   output logic [2:0]             stat
);

   localparam int WIN_W  = WIN_BYTES * 8;
   localparam int BUS_W  = 4 * NIB_W + WORD_W + ADDR_W + 3;
   localparam logic [BUS_W-1:0] RST_VAL =
      {IC_NOP, 4'h0, REG_NONE, REG_NONE, {WORD_W{1'b0}}, ADDR_W'(1), 3'(ST_AOK)};

   if (WORD_W % 8 != 0) begin : g_chk_word
      $error("vlen_decoder: WORD_W must be whole bytes");
   end
   if (WIN_BYTES != 2 + WORD_W / 8) begin : g_chk_win
      $error("vlen_decoder: window must hold opcode, register byte and constant");
   end
   if (ADDR_W < 8) begin : g_chk_addr
      $error("vlen_decoder: ADDR_W too small");
   end

   logic [NIB_W-1:0]  op_code;
   logic [NIB_W-1:0]  op_fun;
   logic              has_reg;
   logic              has_const;
   logic              illegal;
   logic              is_halt;
   logic [NIB_W-1:0]  ra_d;
   logic [NIB_W-1:0]  rb_d;
   logic [WORD_W-1:0] valc_d;
   logic [ADDR_W-1:0] valp_d;
   stat_e             stat_d;
   logic [BUS_W-1:0]  bus_d;
   logic [BUS_W-1:0]  bus_q;

   assign op_code = fetch_win[7:4];
   assign op_fun  = fetch_win[3:0];

   vlen_dec_class u_class (
      .icode_i     (op_code),
      .ifun_i      (op_fun),
      .has_reg_o   (has_reg),
      .has_const_o (has_const),
      .illegal_o   (illegal),
      .is_halt_o   (is_halt)
   );

   vlen_dec_fields #(
      .WORD_W    (WORD_W),
      .WIN_BYTES (WIN_BYTES)
   ) u_fields (
      .tail_i      (fetch_win[WIN_W-1:8]),
      .has_reg_i   (has_reg),
      .has_const_i (has_const),
      .ra_o        (ra_d),
      .rb_o        (rb_d),
      .valc_o      (valc_d)
   );

   vlen_dec_next #(
      .ADDR_W (ADDR_W),
      .WORD_W (WORD_W)
   ) u_next (
      .pc_i        (pc),
      .has_reg_i   (has_reg),
      .has_const_i (has_const),
      .valp_o      (valp_d)
   );

   always_comb begin
      if (mem_err)      stat_d = ST_ADR;
      else if (illegal) stat_d = ST_INS;
      else if (is_halt) stat_d = ST_HLT;
      else              stat_d = ST_AOK;
   end

   assign bus_d = {op_code, op_fun, ra_d, rb_d, valc_d, valp_d, 3'(stat_d)};

   vlen_dec_stage #(
      .BUS_W   (BUS_W),
      .REG_OUT (REG_OUT),
      .RST_VAL (RST_VAL)
   ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (bus_d),
      .q_o   (bus_q)
   );

   assign {icode, ifun, ra, rb, valc, valp, stat} = bus_q;

endmodule

// File: rtl/vlen_decoder_chk.sv
module vlen_decoder_chk
   import vlen_dec_pkg::*;
#(
   parameter int ADDR_W  = 64,
   parameter int WORD_W  = 64,
   parameter bit REG_OUT = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] pc,
   input logic              mem_err,
   input logic [3:0]        icode,
   input logic [3:0]        ifun,
   input logic [3:0]        ra,
   input logic [3:0]        rb,
   input logic [WORD_W-1:0] valc,
   input logic [ADDR_W-1:0] valp,
   input logic [2:0]        stat
);

   logic [ADDR_W-1:0] pc_q;
   logic              err_q;
   logic [ADDR_W-1:0] pc_ref;
   logic              err_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q  <= '0;
         err_q <= 1'b0;
      end else begin
         pc_q  <= pc;
         err_q <= mem_err;
      end
   end

   assign pc_ref  = REG_OUT ? pc_q  : pc;
   assign err_ref = REG_OUT ? err_q : mem_err;

   AST_STAT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      stat inside {3'd1, 3'd2, 3'd3, 3'd4}); // R8

   AST_ADR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      err_ref |-> stat == 3'd3); // R7

   AST_HALT_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      (!err_ref && icode == 4'h0 && ifun == 4'h0) |-> stat == 3'd2); // R8

   AST_NOREG_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      (icode inside {4'h0, 4'h1, 4'h7, 4'h8, 4'h9}) |-> (ra == 4'hF && rb == 4'hF)); // R2

   AST_NOCONST_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      (icode inside {4'h0, 4'h1, 4'h2, 4'h6, 4'h9, 4'hA, 4'hB}) |-> valc == '0); // R3

   AST_ILLEGAL_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == 3'd4) |-> (ra == 4'hF && rb == 4'hF && valc == '0
                          && valp == pc_ref + ADDR_W'(1))); // R5

   AST_LEN_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
      (stat inside {3'd1, 3'd2} && icode inside {4'h0, 4'h1, 4'h9})
      |-> valp == pc_ref + ADDR_W'(1)); // R4

   AST_LEN_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == 3'd1 && icode inside {4'h2, 4'h6, 4'hA, 4'hB})
      |-> valp == pc_ref + ADDR_W'(2)); // R4

   AST_LEN_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == 3'd1 && icode inside {4'h7, 4'h8})
      |-> valp == pc_ref + ADDR_W'(9)); // R4

   AST_LEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (stat == 3'd1 && icode inside {4'h3, 4'h4, 4'h5})
      |-> valp == pc_ref + ADDR_W'(10)); // R4

   AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (icode > 4'hB && !err_ref) |-> stat == 3'd4); // R5

endmodule

bind vlen_decoder vlen_decoder_chk #(
   .ADDR_W  (ADDR_W),
   .WORD_W  (WORD_W),
   .REG_OUT (REG_OUT)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pc      (pc),
   .mem_err (mem_err),
   .icode   (icode),
   .ifun    (ifun),
   .ra      (ra),
   .rb      (rb),
   .valc    (valc),
   .valp    (valp),
   .stat    (stat)
);

// File: tb/vlen_decoder_test.sv
`timescale 1ns/1ps
module vlen_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [79:0] fetch_win = '0;
   logic [63:0] pc = '0;
   logic        mem_err = 1'b0;
   logic [3:0]  icode, ifun, ra, rb;
   logic [63:0] valc, valp;
   logic [2:0]  stat;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   vlen_decoder uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .fetch_win (fetch_win),
      .pc        (pc),
      .mem_err   (mem_err),
      .icode     (icode),
      .ifun      (ifun),
      .ra        (ra),
      .rb        (rb),
      .valc      (valc),
      .valp      (valp),
      .stat      (stat)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [79:0] w, input logic [63:0] a, input logic e);
      @(negedge clk);
      fetch_win = w;
      pc        = a;
      mem_err   = e;
      @(posedge clk);
      #1;
   endtask

   task automatic expect_all(input string tag, input logic [3:0] ic, input logic [3:0] fn,
                             input logic [3:0] xa, input logic [3:0] xb,
                             input logic [63:0] xc, input logic [63:0] xp,
                             input logic [2:0] xs);
      chk({tag, " R1 icode"}, 64'(icode), 64'(ic));
      chk({tag, " R1 ifun"},  64'(ifun),  64'(fn));
      chk({tag, " R2 ra"},    64'(ra),    64'(xa));
      chk({tag, " R2 rb"},    64'(rb),    64'(xb));
      chk({tag, " R3 valc"},  valc,       xc);
      chk({tag, " R4 valp"},  valp,       xp);
      chk({tag, " R8 stat"},  64'(stat),  64'(xs));
   endtask

   task automatic t_reset;
      #1;
      expect_all("R9 reset", 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, 64'h1, 3'd1);
   endtask

   task automatic t_short;
      drive(80'h00, 64'h100, 1'b0);
      expect_all("R8 halt", 4'h0, 4'h0, 4'hF, 4'hF, 64'h0, 64'h101, 3'd2);
      drive({72'hFFEEDDCCBBAA998877, 8'h10}, 64'h200, 1'b0);
      expect_all("R4 nop", 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, 64'h201, 3'd1);
      drive({72'h123456789ABCDEF012, 8'h90}, 64'h300, 1'b0);
      expect_all("R3 ret", 4'h9, 4'h0, 4'hF, 4'hF, 64'h0, 64'h301, 3'd1);
   endtask

   task automatic t_regbyte;
      drive({64'hDEADBEEFCAFEF00D, 8'h3A, 8'h25}, 64'h400, 1'b0);
      expect_all("R2 cmov", 4'h2, 4'h5, 4'h3, 4'hA, 64'h0, 64'h402, 3'd1);
      drive({64'h0, 8'h4F, 8'hA0}, 64'h500, 1'b0);
      expect_all("R2 push", 4'hA, 4'h0, 4'h4, 4'hF, 64'h0, 64'h502, 3'd1);
      drive({64'h0, 8'hE1, 8'h63}, 64'h510, 1'b0);
      expect_all("R6 alu3", 4'h6, 4'h3, 4'hE, 4'h1, 64'h0, 64'h512, 3'd1);
   endtask

   task automatic t_const;
      drive({64'h1122334455667788, 8'hF2, 8'h30}, 64'h600, 1'b0);
      expect_all("R3 imov", 4'h3, 4'h0, 4'hF, 4'h2, 64'h1122334455667788, 64'h60A, 3'd1);
      drive({64'h0000000000000010, 8'h57, 8'h50}, 64'h700, 1'b0);
      expect_all("R3 load", 4'h5, 4'h0, 4'h5, 4'h7, 64'h10, 64'h70A, 3'd1);
      drive({8'hEE, 64'h0807060504030201, 8'h76}, 64'h800, 1'b0);
      expect_all("R3 jump", 4'h7, 4'h6, 4'hF, 4'hF, 64'h0807060504030201, 64'h809, 3'd1);
      drive({8'h55, 64'h0000000000000ABC, 8'h80}, 64'hFFFF_FFFF_FFFF_FFFC, 1'b0);
      expect_all("R4 call wrap", 4'h8, 4'h0, 4'hF, 4'hF, 64'hABC, 64'h5, 3'd1);
   endtask

   task automatic t_illegal;
      drive({64'h1111111111111111, 8'h12, 8'hC0}, 64'h900, 1'b0);
      expect_all("R5 code", 4'hC, 4'h0, 4'hF, 4'hF, 64'h0, 64'h901, 3'd4);
      drive({64'h0, 8'h12, 8'h27}, 64'hA00, 1'b0);
      expect_all("R6 cmov7", 4'h2, 4'h7, 4'hF, 4'hF, 64'h0, 64'hA01, 3'd4);
      drive({64'h0, 8'h12, 8'h64}, 64'hB00, 1'b0);
      expect_all("R6 alu4", 4'h6, 4'h4, 4'hF, 4'hF, 64'h0, 64'hB01, 3'd4);
      drive({64'h0, 8'h12, 8'h91}, 64'hC00, 1'b0);
      expect_all("R6 ret1", 4'h9, 4'h1, 4'hF, 4'hF, 64'h0, 64'hC01, 3'd4);
      drive({8'h0, 64'h99, 8'h77}, 64'hD00, 1'b0);
      expect_all("R6 jump7", 4'h7, 4'h7, 4'hF, 4'hF, 64'h0, 64'hD01, 3'd4);
   endtask

   task automatic t_adr_overlap;
      drive(80'h00, 64'hE00, 1'b1);
      expect_all("R7 adr+halt", 4'h0, 4'h0, 4'hF, 4'hF, 64'h0, 64'hE01, 3'd3);
      drive({64'h0, 8'h12, 8'hF0}, 64'hE10, 1'b1);
      expect_all("R7 adr+bad", 4'hF, 4'h0, 4'hF, 4'hF, 64'h0, 64'hE11, 3'd3);
      drive({64'h0, 8'h0, 8'h10}, 64'hE20, 1'b1);
      expect_all("R7 adr+nop", 4'h1, 4'h0, 4'hF, 4'hF, 64'h0, 64'hE21, 3'd3);
      drive({64'h0, 8'h0, 8'h10}, 64'hE30, 1'b0);
      chk("R8 recover stat", 64'(stat), 64'd1);
   endtask

   task automatic t_latency;
      drive({64'h0, 8'h21, 8'h60}, 64'hF00, 1'b0);
      @(negedge clk);
      fetch_win = {64'h0, 8'h00, 8'hC0};
      pc        = 64'hF10;
      #1;
      chk("R9 hold icode", 64'(icode), 64'h6);
      chk("R9 hold valp",  valp,       64'hF02);
      @(posedge clk);
      #1;
      chk("R9 update icode", 64'(icode), 64'hC);
      chk("R9 update stat",  64'(stat),  64'd4);
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_short();
      t_regbyte();
      t_const();
      t_illegal();
      t_adr_overlap();
      t_latency();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule